// File: doc/BRIEF.md
# Test-Under-Mask Condition Code Unit

This unit executes a four-byte instruction that probes one 16-bit halfword of a 64-bit general register. The second byte names the register, which the unit presents at once on an index port to an external register-file read port, and picks the halfword. The last two bytes are a 16-bit immediate. Each set bit of the immediate selects one bit of the chosen halfword. The unit then registers a 2-bit condition code that sorts the selected bits into four classes: all clear, all set, or mixed. The mixed case is split in two by the value of the most significant selected bit.

A second, independent path evaluates a 4-bit branch mask against the registered condition code. It gives a combinational branch-taken signal, which lets a sequencer resolve a conditional branch in the cycle after the test. Instruction words with an unknown primary opcode or an out-of-range sub-opcode raise a one-cycle illegal flag and leave the condition code untouched.

Top module: `tmask_cc_unit`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `cc_o` is 0, `illegal_o` is 0 and no branch is taken unless requested.
- R2: The instruction word is laid out as follows: bits 31:24 must be 0xA7, bits 23:20 are the register number, bits 19:16 are the sub-opcode, and bits 15:0 are the immediate. Sub-opcode 0 tests register bits 31:16, sub-opcode 1 tests bits 15:0, sub-opcode 2 tests bits 63:48 and sub-opcode 3 tests bits 47:32. The result appears on `cc_o` after the rising edge that samples `insn_vld_i` high.
- R3: The code is 0 when every selected bit is clear. This includes an immediate of 0x0000, which selects nothing.
- R4: The code is 3 when at least one bit is selected and every selected bit is set.
- R5: When the selected bits are mixed, the code is 1 if the bit under the most significant set bit of the immediate is 0, and 2 if that bit is 1. An immediate with a single set bit therefore never yields 1 or 2.
- R6: `reg_idx_o` equals instruction bits 23:20 in the same cycle, and `reg_val_i` is consumed in that same cycle.
- R7: A valid word whose bits 31:24 differ from 0xA7, or whose sub-opcode exceeds 3, drives `illegal_o` high for exactly the following cycle and leaves `cc_o` unchanged.
- R8: In a cycle with `insn_vld_i` low, the instruction word and the register value have no effect, and `cc_o` holds.
- R9: `br_taken_o` is `br_vld_i` AND bit (3 − `cc_o`) of `br_mask_i`. Bit 3 of the mask stands for code 0, and bit 0 stands for code 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_i | input | 32 | Instruction word |
| insn_vld_i | input | 1 | Instruction word is valid this cycle |
| reg_idx_o | output | 4 | Register number sent to the register-file read port |
| reg_val_i | input | 64 | Register value returned by the read port, same cycle |
| br_mask_i | input | 4 | Branch condition mask, one bit per code, code 0 leftmost |
| br_vld_i | input | 1 | Branch evaluation request |
| cc_o | output | 2 | Registered condition code |
| illegal_o | output | 1 | One-cycle flag for an undecodable valid word |
| br_taken_o | output | 1 | Branch condition met by the current code |

## Verification
The assertions take two things for granted. First, `reg_val_i` is a pure function of `reg_idx_o` within the cycle. Second, `insn_vld_i` is low while reset is held, so the past-cycle properties see no strobe before the first edge. The stimulus respects both. The register value comes from a bench-side register array indexed by the unit's own index output, and every input is driven only after reset release and away from the rising edge. Instruction words and junk data are still applied in cycles with the strobe low, to probe that they have no effect.

// File: rtl/tmask_pkg.sv
package tmask_pkg;

    // Condition code classes produced by a halfword probe
    typedef enum logic [1:0] {
        CC_NONE_SET = 2'd0,
        CC_MIX_LEAD0 = 2'd1,
        CC_MIX_LEAD1 = 2'd2,
        CC_ALL_SET  = 2'd3
    } tm_cc_e;

    // Registered state of the unit
    typedef struct packed {
        tm_cc_e cc;
        logic   illegal;
    } tm_state_t;

    localparam tm_state_t TM_STATE_RESET = '{cc: CC_NONE_SET, illegal: 1'b0};

endpackage

// File: rtl/tmask_decode.sv
module tmask_decode #(
    parameter int          INSN_W     = 32,
    parameter int          HALF_W     = 16,
    parameter int          N_HALVES   = 4,
    parameter int          RIDX_W     = 4,
    parameter int          SUB_W      = 4,
    parameter logic [7:0]  PRIMARY_OP = 8'hA7,
    localparam int         HSEL_W     = $clog2(N_HALVES)
) (
    input  logic [INSN_W-1:0] insn_i,
    output logic              legal_o,
    output logic [RIDX_W-1:0] reg_idx_o,
    output logic [HSEL_W-1:0] half_sel_o,
    output logic [HALF_W-1:0] imm_o
);
    localparam int OP_LSB   = INSN_W - 8;
    localparam int RIDX_LSB = OP_LSB - RIDX_W;
    localparam int SUB_LSB  = RIDX_LSB - SUB_W;

    logic [7:0]       op_byte;
    logic [SUB_W-1:0] sub_op;

    always_comb begin
        op_byte    = insn_i[INSN_W-1 -: 8];
        reg_idx_o  = insn_i[OP_LSB-1 -: RIDX_W];
        sub_op     = insn_i[RIDX_LSB-1 -: SUB_W];
        imm_o      = insn_i[HALF_W-1:0];
        legal_o    = (op_byte == PRIMARY_OP) && (sub_op < SUB_W'(N_HALVES));
        // Even sub-opcodes address the upper half of a word, odd the lower
        half_sel_o = sub_op[HSEL_W-1:0] ^ HSEL_W'(1);
    end

endmodule

// File: rtl/tmask_classify.sv
module tmask_classify
    import tmask_pkg::*;
#(
    parameter int  HALF_W   = 16,
    parameter int  N_HALVES = 4,
    localparam int DATA_W   = HALF_W * N_HALVES,
    localparam int HSEL_W   = $clog2(N_HALVES)
) (
    input  logic [DATA_W-1:0] operand_i,
    input  logic [HSEL_W-1:0] half_sel_i,
    input  logic [HALF_W-1:0] imm_i,
    output tm_cc_e            cc_o
);
    logic [HALF_W-1:0] halves [N_HALVES];
    logic [HALF_W-1:0] sel_half;
    logic [HALF_W-1:0] picked;
    logic [HALF_W-1:0] lead_onehot;
    logic              lead_bit;

    for (genvar h = 0; h < N_HALVES; h++) begin : g_half
        assign halves[h] = operand_i[h*HALF_W +: HALF_W];
    end

    // Priority encoder: one-hot of the most significant immediate bit
    for (genvar b = 0; b < HALF_W; b++) begin : g_lead
        if (b == HALF_W - 1) begin : g_top
            assign lead_onehot[b] = imm_i[b];
        end else begin : g_rest
            assign lead_onehot[b] = imm_i[b] & ~(|imm_i[HALF_W-1:b+1]);
        end
    end

    always_comb begin
        sel_half = halves[half_sel_i];
        picked   = sel_half & imm_i;
        lead_bit = |(lead_onehot & sel_half);
        if (picked == '0) begin
            cc_o = CC_NONE_SET;
        end else if (picked == imm_i) begin
            cc_o = CC_ALL_SET;
        end else if (lead_bit) begin
            cc_o = CC_MIX_LEAD1;
        end else begin
            cc_o = CC_MIX_LEAD0;
        end
    end

endmodule

// File: rtl/tmask_branch_eval.sv
module tmask_branch_eval
    import tmask_pkg::*;
#(
    parameter  int N_CODES = 4,
    localparam int CC_W    = $clog2(N_CODES)
) (
    input  tm_cc_e             cc_i,
    input  logic [N_CODES-1:0] mask_i,
    input  logic               vld_i,
    output logic               taken_o
);
    logic [CC_W-1:0] bit_pos;

    always_comb begin
        // Mask is big-endian: leftmost bit belongs to code 0
        bit_pos = CC_W'(N_CODES - 1) - CC_W'(cc_i);
        taken_o = vld_i & mask_i[bit_pos];
    end

endmodule

// File: rtl/tmask_cc_unit.sv
module tmask_cc_unit
    import tmask_pkg::*;
#(
    parameter int         HALF_W     = 16,
    parameter int         N_HALVES   = 4,
    parameter int         RIDX_W     = 4,
    parameter int         SUB_W      = 4,
    parameter logic [7:0] PRIMARY_OP = 8'hA7,
    localparam int        DATA_W     = HALF_W * N_HALVES,
    localparam int        INSN_W     = 8 + RIDX_W + SUB_W + HALF_W,
    localparam int        HSEL_W     = $clog2(N_HALVES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INSN_W-1:0] insn_i,
    input  logic              insn_vld_i,
    output logic [RIDX_W-1:0] reg_idx_o,
    input  logic [DATA_W-1:0] reg_val_i,
    input  logic [3:0]        br_mask_i,
    input  logic              br_vld_i,
    output logic [1:0]        cc_o,
    output logic              illegal_o,
    output logic              br_taken_o
);
    tm_state_t         state_d, state_q;
    logic              legal;
    logic [HSEL_W-1:0] half_sel;
    logic [HALF_W-1:0] imm;
    tm_cc_e            cc_new;

    tmask_decode #(
        .INSN_W    (INSN_W),
        .HALF_W    (HALF_W),
        .N_HALVES  (N_HALVES),
        .RIDX_W    (RIDX_W),
        .SUB_W     (SUB_W),
        .PRIMARY_OP(PRIMARY_OP)
    ) i_decode (
        .insn_i    (insn_i),
        .legal_o   (legal),
        .reg_idx_o (reg_idx_o),
        .half_sel_o(half_sel),
        .imm_o     (imm)
    );

    tmask_classify #(
        .HALF_W  (HALF_W),
        .N_HALVES(N_HALVES)
    ) i_classify (
        .operand_i (reg_val_i),
        .half_sel_i(half_sel),
        .imm_i     (imm),
        .cc_o      (cc_new)
    );

    tmask_branch_eval #(
        .N_CODES(4)
    ) i_branch (
        .cc_i   (state_q.cc),
        .mask_i (br_mask_i),
        .vld_i  (br_vld_i),
        .taken_o(br_taken_o)
    );

    always_comb begin
        state_d         = state_q;
        state_d.illegal = 1'b0;
        if (insn_vld_i) begin
            if (legal) begin
                state_d.cc = cc_new;
            end else begin
                state_d.illegal = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TM_STATE_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign cc_o      = state_q.cc;
    assign illegal_o = state_q.illegal;

endmodule

// File: rtl/tmask_cc_checker.sv
module tmask_cc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] insn_i,
    input logic        insn_vld_i,
    input logic        br_vld_i,
    input logic [1:0]  cc_o,
    input logic        illegal_o,
    input logic        br_taken_o
);
    logic good_word;
    assign good_word = insn_vld_i && (insn_i[31:24] == 8'hA7) && (insn_i[19:18] == 2'b00);

    AST_ZERO_IMM_GIVES_CC0: assert property (@(posedge clk) disable iff (!rst_n)
        (good_word && insn_i[15:0] == 16'h0000) |=> (cc_o == 2'd0)); // R3

    AST_ONE_BIT_NEVER_MIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (good_word && $countones(insn_i[15:0]) == 1) |=> (cc_o == 2'd0 || cc_o == 2'd3)); // R5

    AST_ILLEGAL_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> $past(insn_vld_i)); // R7

    AST_ILLEGAL_KEEPS_CC: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> $stable(cc_o)); // R7

    AST_IDLE_HOLDS_CC: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_vld_i |=> $stable(cc_o)); // R8

    AST_TAKEN_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken_o |-> br_vld_i); // R9

endmodule

bind tmask_cc_unit tmask_cc_checker i_tmask_cc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .insn_i    (insn_i),
    .insn_vld_i(insn_vld_i),
    .br_vld_i  (br_vld_i),
    .cc_o      (cc_o),
    .illegal_o (illegal_o),
    .br_taken_o(br_taken_o)
);

// File: tb/test_tmask_cc_unit.sv
module test_tmask_cc_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] insn_i = '0;
    logic        insn_vld_i = 1'b0;
    logic [3:0]  reg_idx_o;
    logic [63:0] reg_val_i;
    logic [3:0]  br_mask_i = '0;
    logic        br_vld_i = 1'b0;
    logic [1:0]  cc_o;
    logic        illegal_o;
    logic        br_taken_o;

    int    errs = 0;
    int    checks = 0;
    string cur_req = "R1";
    bit    done = 1'b0;

    logic [63:0] regs [16];
    logic [1:0]  exp_cc;
    logic        exp_ill;

    always #2 clk = ~clk;   // 250 MHz

    assign reg_val_i = regs[reg_idx_o];

    tmask_cc_unit i_tmask_cc_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .insn_i    (insn_i),
        .insn_vld_i(insn_vld_i),
        .reg_idx_o (reg_idx_o),
        .reg_val_i (reg_val_i),
        .br_mask_i (br_mask_i),
        .br_vld_i  (br_vld_i),
        .cc_o      (cc_o),
        .illegal_o (illegal_o),
        .br_taken_o(br_taken_o)
    );

    // Behavioural reference for the condition code
    function automatic logic [1:0] ref_cc(input logic [63:0] val, input int sub, input logic [15:0] msk);
        int   base;
        int   n_sel;
        int   n_one;
        int   lead;
        base = (sub == 0) ? 16 : (sub == 1) ? 0 : (sub == 2) ? 48 : 32;
        n_sel = 0;
        n_one = 0;
        lead = -1;
        for (int i = 15; i >= 0; i--) begin
            if (msk[i]) begin
                n_sel++;
                if (val[base + i]) n_one++;
                if (lead < 0) lead = int'(val[base + i]);
            end
        end
        if (n_one == 0)          return 2'd0;
        else if (n_one == n_sel) return 2'd3;
        else if (lead == 1)      return 2'd2;
        else                     return 2'd1;
    endfunction

    function automatic bit word_ok(input logic [31:0] w);
        return (w[31:24] == 8'hA7) && (w[19:16] <= 4'd3);
    endfunction

    // Reference model, advanced on each rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            exp_cc  <= 2'd0;
            exp_ill <= 1'b0;
        end else begin
            exp_ill <= insn_vld_i && !word_ok(insn_i);
            if (insn_vld_i && word_ok(insn_i))
                exp_cc <= ref_cc(regs[insn_i[23:20]], int'(insn_i[19:16]), insn_i[15:0]);
        end
    end

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // Compare every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            chk("cc_o", 64'(cc_o), 64'(exp_cc));
            chk("illegal_o", 64'(illegal_o), 64'(exp_ill));
            chk("br_taken_o", 64'(br_taken_o), 64'(br_vld_i && br_mask_i[3 - int'(exp_cc)]));
            chk("reg_idx_o", 64'(reg_idx_o), 64'(insn_i[23:20]));   // R6
        end
    end

    task automatic drive(input logic [31:0] w, input logic v);
        @(negedge clk);
        #1;
        insn_i     = w;
        insn_vld_i = v;
    endtask

    function automatic logic [31:0] mk(input logic [7:0] op, input int r, input int sub, input logic [15:0] m);
        return {op, 4'(r), 4'(sub), m};
    endfunction

    initial begin
        logic [15:0] masks [8];
        masks = '{16'h0000, 16'h0001, 16'h8000, 16'hFFFF, 16'h00F0, 16'h0F0F, 16'hA5A5, 16'h7FFE};
        regs[0] = '0;
        regs[1] = '1;
        for (int k = 2; k < 16; k++)
            regs[k] = (64'h9E37_79B9_7F4A_7C15 * 64'(k)) ^ (64'hFFFF << (k * 3));
        regs[2] = 64'h00FF_FF00_0F0F_00FF;
        regs[3] = 64'hFF00_00FF_F0F0_FF00;

        // R1: reset state observed during and after reset
        cur_req = "R1";
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 R3 R4 R5 R6: every register, sub-opcode and mask; R7 for sub-opcodes 4 and 5
        cur_req = "R2/R3/R4/R5/R6/R7";
        for (int r = 0; r < 16; r++)
            for (int s = 0; s < 6; s++)
                for (int m = 0; m < 8; m++)
                    drive(mk(8'hA7, r, s, masks[m]), 1'b1);

        // R7: wrong primary opcode, back to back and isolated
        cur_req = "R7";
        drive(mk(8'hA7, 1, 1, 16'hFFFF), 1'b1);
        drive(mk(8'hA6, 0, 1, 16'hFFFF), 1'b1);
        drive(mk(8'h00, 0, 0, 16'h0001), 1'b1);
        drive(mk(8'hA7, 2, 15, 16'h00FF), 1'b1);
        drive(32'h0, 1'b0);
        drive(32'h0, 1'b0);

        // R8: legal words without strobe must not move the code
        cur_req = "R8";
        drive(mk(8'hA7, 1, 0, 16'hFFFF), 1'b1);
        for (int r = 0; r < 16; r++)
            drive(mk(8'hA7, r, r % 4, 16'h1234), 1'b0);

        // R9: every code against every branch mask
        cur_req = "R9";
        for (int c = 0; c < 4; c++) begin
            case (c)
                0: drive(mk(8'hA7, 0, 1, 16'hFFFF), 1'b1);
                1: drive(mk(8'hA7, 2, 1, 16'hFFFF), 1'b1);   // 0x00FF: lead 0
                2: drive(mk(8'hA7, 3, 1, 16'hFFFF), 1'b1);   // 0xFF00: lead 1
                default: drive(mk(8'hA7, 1, 1, 16'hFFFF), 1'b1);
            endcase
            drive(32'h0, 1'b0);
            for (int bm = 0; bm < 16; bm++) begin
                @(negedge clk);
                #1;
                br_mask_i = 4'(bm);
                br_vld_i  = 1'b1;
            end
            @(negedge clk);
            #1;
            br_mask_i = 4'hF;
            br_vld_i  = 1'b0;
            @(negedge clk);
            checks++;
            if (int'(cc_o) != c) begin
                errs++;
                $display("FAIL R9 setup code: actual=%0d expected=%0d", cc_o, c);
            end
        end

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errs++;
        checks++;
        done = 1'b1;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule